// File: doc/BRIEF.md
# Boot Source Sequencer

This block decides which boot medium a boot controller attempts and in what order. It samples a 3-bit strap input once after reset and uses it to pick one of eight fixed priority lists. It then walks the chosen list one source at a time. For each source it raises a try request and waits for a pass or fail answer from the medium handler. If no answer arrives within a programmable number of cycles, the attempt counts as a fail. An eMMC entry is expanded into three attempts, one for each hardware partition. The block stops at the first source that passes. It raises a failure flag when the list runs out.

A recovery detector can ask for USB device or SD card to be tried ahead of the list. If that forced attempt fails, the normal strap sequence runs from its first entry. A forced USB choice is remembered across warm resets, so later warm restarts also begin with USB. Only a cold (power-on) reset forgets it. The block drives every request with a fixed image start address. Media protocols and image checking sit outside the block.

Top module: `boot_source_seq`

## Requirements
- R1: Source codes are 1 SPI NOR, 2 SPI NAND, 3 eMMC main, 4 eMMC Boot0, 5 eMMC Boot1, 6 SD card, 7 USB device (0 = none). The strap selects the list: 000 gives 7,1,eMMC,6. 001 gives 7,eMMC,6. 010 gives 1,eMMC,6,7. 011 gives 2,eMMC,7. 111 gives eMMC,6,7.
- R2: After a failed attempt, the next request carries the next list entry.
- R3: An eMMC entry produces attempts 3, 4 and 5 in that order. The walk leaves eMMC only after all three fail.
- R4: Whenever try_req is high, try_addr equals 512 (sector 1 of 512-byte sectors).
- R5: try_req stays high with a stable try_src until a try_ack or a timeout, and then drops for at least one cycle. A timeout is a fail. It occurs when tmo_limit cycles pass with no ack.
- R6: If rcv_force is high when the walk starts, the first attempt is 6 (rcv_to_sd=1) or 7 (rcv_to_sd=0). The full strap list follows if that attempt fails.
- R7: After a forced USB start, every warm reset (rst_n) starts again with attempt 7. A cold reset (por_n) clears this.
- R8: When the last entry fails, boot_fail goes high, boot_src reads 0, and no further request is made until reset.
- R9: On a pass, boot_done goes high and boot_src holds the code that passed. No further request is made.
- R10: While in reset, try_req, boot_done and boot_fail are low and boot_src is 0.
- R11: Straps 100, 101 and 110 give the same lists as 000, 001 and 010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Cold (power-on) reset, active low, asynchronous |
| rst_n | input | 1 | Warm reset, active low, asynchronous |
| strap | input | 3 | Boot order strap, sampled once after reset |
| rcv_force | input | 1 | Recovery override request |
| rcv_to_sd | input | 1 | Override target: 1 SD card, 0 USB device |
| tmo_limit | input | TMO_W | Attempt timeout in cycles |
| try_ack | input | 1 | Attempt finished (one-cycle pulse) |
| try_pass | input | 1 | Attempt result, valid with try_ack |
| try_req | output | 1 | Attempt request |
| try_src | output | 3 | Source code of the current attempt |
| try_addr | output | ADDR_W | Image start byte address |
| boot_src | output | 3 | Source in use, or passing source once done |
| boot_done | output | 1 | A source passed |
| boot_fail | output | 1 | All sources failed |

## Verification
The bench runs all eight straps. For each one it compares the full order of attempt codes against an expected queue, with a different source set to pass in each run. An ordering that swapped eMMC partitions or treated strap bit 2 as significant would pop the wrong code. One run leaves SPI NAND unanswered to exercise the timeout path; a design that waited forever would trip the watchdog. Further runs cover the SD and USB overrides and a sequence of warm and cold resets. A design that reset the USB memory on a warm reset, or kept it through a cold one, would issue a wrong first attempt.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic [2:0] {
    SRC_NONE      = 3'd0,
    SRC_SPI_NOR   = 3'd1,
    SRC_SPI_NAND  = 3'd2,
    SRC_EMMC_MAIN = 3'd3,
    SRC_EMMC_B0   = 3'd4,
    SRC_EMMC_B1   = 3'd5,
    SRC_SD        = 3'd6,
    SRC_USB       = 3'd7
  } src_e;

  typedef enum logic [2:0] {
    ST_START = 3'd0,
    ST_WAIT  = 3'd1,
    ST_NEXT  = 3'd2,
    ST_DONE  = 3'd3,
    ST_FAIL  = 3'd4
  } st_e;

  localparam int LIST_LEN = 4;
  localparam int IDX_W    = $clog2(LIST_LEN);
endpackage

// File: rtl/bsq_rst_sync.sv
module bsq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/bsq_order_rom.sv
module bsq_order_rom
  import bsq_pkg::*;
(
  input  logic [2:0]       strap,
  input  logic [IDX_W-1:0] idx,
  output src_e             entry
);
  always_comb begin
    entry = SRC_NONE;
    if (strap == 3'b111) begin
      case (idx)
        2'd0:    entry = SRC_EMMC_MAIN;
        2'd1:    entry = SRC_SD;
        2'd2:    entry = SRC_USB;
        default: entry = SRC_NONE;
      endcase
    end else begin
      case (strap[1:0])
        2'b00: begin
          case (idx)
            2'd0:    entry = SRC_USB;
            2'd1:    entry = SRC_SPI_NOR;
            2'd2:    entry = SRC_EMMC_MAIN;
            default: entry = SRC_SD;
          endcase
        end
        2'b01: begin
          case (idx)
            2'd0:    entry = SRC_USB;
            2'd1:    entry = SRC_EMMC_MAIN;
            2'd2:    entry = SRC_SD;
            default: entry = SRC_NONE;
          endcase
        end
        2'b10: begin
          case (idx)
            2'd0:    entry = SRC_SPI_NOR;
            2'd1:    entry = SRC_EMMC_MAIN;
            2'd2:    entry = SRC_SD;
            default: entry = SRC_USB;
          endcase
        end
        default: begin
          case (idx)
            2'd0:    entry = SRC_SPI_NAND;
            2'd1:    entry = SRC_EMMC_MAIN;
            2'd2:    entry = SRC_USB;
            default: entry = SRC_NONE;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/bsq_timeout.sv
module bsq_timeout #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign expired = run && (cnt_q >= limit);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (!expired) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/boot_source_seq.sv
module boot_source_seq
  import bsq_pkg::*;
#(
  parameter int TMO_W        = 16,
  parameter int ADDR_W       = 32,
  parameter int SECTOR_BYTES = 512,
  parameter int IMG_SECTOR   = 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [2:0]        strap,
  input  logic              rcv_force,
  input  logic              rcv_to_sd,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              try_ack,
  input  logic              try_pass,
  output logic              try_req,
  output logic [2:0]        try_src,
  output logic [ADDR_W-1:0] try_addr,
  output logic [2:0]        boot_src,
  output logic              boot_done,
  output logic              boot_fail
);
  localparam logic [ADDR_W-1:0] IMG_ADDR = ADDR_W'(SECTOR_BYTES * IMG_SECTOR);

  logic cold_srst_n;
  logic warm_srst_n;
  logic warm_arst_n;

  assign warm_arst_n = rst_n & por_n;

  bsq_rst_sync #(.STAGES(2)) u_sync_cold (
    .clk(clk), .arst_n(por_n), .srst_n(cold_srst_n)
  );
  bsq_rst_sync #(.STAGES(2)) u_sync_warm (
    .clk(clk), .arst_n(warm_arst_n), .srst_n(warm_srst_n)
  );

  st_e              state_q, state_d;
  src_e             cur_q, cur_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             forced_q, forced_d;
  logic [2:0]       strap_q, strap_d;
  logic             usb_mem_q;
  logic             usb_mem_set;

  logic [2:0]       rom_strap;
  logic [IDX_W-1:0] rom_idx;
  src_e             rom_entry;
  logic             tmo_hit;
  logic             in_wait;
  logic             is_last;

  assign in_wait   = (state_q == ST_WAIT);
  assign rom_strap = (state_q == ST_START) ? strap : strap_q;
  assign rom_idx   = (state_q == ST_NEXT && !forced_q) ? idx_q + 1'b1 : '0;
  assign is_last   = (idx_q == IDX_W'(LIST_LEN - 1));

  bsq_order_rom u_rom (
    .strap(rom_strap), .idx(rom_idx), .entry(rom_entry)
  );

  bsq_timeout #(.W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(warm_srst_n), .run(in_wait),
    .limit(tmo_limit), .expired(tmo_hit)
  );

  always_comb begin
    state_d     = state_q;
    cur_d       = cur_q;
    idx_d       = idx_q;
    forced_d    = forced_q;
    strap_d     = strap_q;
    usb_mem_set = 1'b0;
    case (state_q)
      ST_START: begin
        strap_d = strap;
        idx_d   = '0;
        state_d = ST_WAIT;
        if (usb_mem_q || (rcv_force && !rcv_to_sd)) begin
          forced_d    = 1'b1;
          cur_d       = SRC_USB;
          usb_mem_set = 1'b1;
        end else if (rcv_force) begin
          forced_d = 1'b1;
          cur_d    = SRC_SD;
        end else begin
          forced_d = 1'b0;
          cur_d    = rom_entry;
        end
      end
      ST_WAIT: begin
        if (try_ack) state_d = try_pass ? ST_DONE : ST_NEXT;
        else if (tmo_hit) state_d = ST_NEXT;
      end
      ST_NEXT: begin
        state_d = ST_WAIT;
        if (forced_q) begin
          forced_d = 1'b0;
          idx_d    = '0;
          cur_d    = rom_entry;
        end else if (cur_q == SRC_EMMC_MAIN) begin
          cur_d = SRC_EMMC_B0;
        end else if (cur_q == SRC_EMMC_B0) begin
          cur_d = SRC_EMMC_B1;
        end else if (is_last || rom_entry == SRC_NONE) begin
          cur_d   = SRC_NONE;
          state_d = ST_FAIL;
        end else begin
          idx_d = idx_q + 1'b1;
          cur_d = rom_entry;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge warm_srst_n) begin
    if (!warm_srst_n) begin
      state_q  <= ST_START;
      cur_q    <= SRC_NONE;
      idx_q    <= '0;
      forced_q <= 1'b0;
      strap_q  <= '0;
    end else begin
      state_q  <= state_d;
      cur_q    <= cur_d;
      idx_q    <= idx_d;
      forced_q <= forced_d;
      strap_q  <= strap_d;
    end
  end

  always_ff @(posedge clk or negedge cold_srst_n) begin
    if (!cold_srst_n)     usb_mem_q <= 1'b0;
    else if (usb_mem_set) usb_mem_q <= 1'b1;
  end

  assign try_req   = in_wait;
  assign try_src   = cur_q;
  assign try_addr  = IMG_ADDR;
  assign boot_src  = cur_q;
  assign boot_done = (state_q == ST_DONE);
  assign boot_fail = (state_q == ST_FAIL);
endmodule

// File: rtl/boot_source_seq_chk.sv
module boot_source_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic              try_ack,
  input logic              try_req,
  input logic [2:0]        try_src,
  input logic [ADDR_W-1:0] try_addr,
  input logic [2:0]        boot_src,
  input logic              boot_done,
  input logic              boot_fail
);
  logic       req_q;
  logic [2:0] last_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      last_src <= 3'd0;
    end else begin
      req_q <= try_req;
      if (try_req && !req_q) last_src <= try_src;
    end
  end

  p_addr_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    try_req |-> try_addr == ADDR_W'(512));

  p_src_hold_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (try_req && !try_ack) |=> (!try_req || $stable(try_src)));

  p_ack_drop_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (try_req && try_ack) |=> !try_req);

  p_b0_after_main_r3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (try_req && !req_q && try_src == 3'd4) |-> last_src == 3'd3);

  p_b1_after_b0_r3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (try_req && !req_q && try_src == 3'd5) |-> last_src == 3'd4);

  p_fail_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    boot_fail |=> (boot_fail && !try_req && boot_src == 3'd0));

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    boot_done |=> (boot_done && !try_req && !boot_fail && $stable(boot_src)));
endmodule

bind boot_source_seq boot_source_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .try_ack(try_ack),
  .try_req(try_req), .try_src(try_src), .try_addr(try_addr),
  .boot_src(boot_src), .boot_done(boot_done), .boot_fail(boot_fail)
);

// File: tb/boot_source_seq_tb.sv
`timescale 1ns/1ps
module boot_source_seq_tb;
  logic        clk = 1'b0;
  logic        por_n, rst_n;
  logic [2:0]  strap;
  logic        rcv_force, rcv_to_sd;
  logic [15:0] tmo_limit;
  logic        try_ack, try_pass;
  logic        try_req;
  logic [2:0]  try_src;
  logic [31:0] try_addr;
  logic [2:0]  boot_src;
  logic        boot_done, boot_fail;

  int checks = 0;
  int fails  = 0;
  logic [2:0] exp_q[$];
  logic [7:0] pass_mask;
  logic [7:0] silent_mask;
  logic       in_reset;

  always #2.5 clk = ~clk;

  boot_source_seq u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .strap(strap),
    .rcv_force(rcv_force), .rcv_to_sd(rcv_to_sd), .tmo_limit(tmo_limit),
    .try_ack(try_ack), .try_pass(try_pass), .try_req(try_req),
    .try_src(try_src), .try_addr(try_addr), .boot_src(boot_src),
    .boot_done(boot_done), .boot_fail(boot_fail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // responder: answers each request two cycles in, unless silenced
  initial begin
    int wcnt;
    wcnt = 0;
    try_ack = 1'b0;
    try_pass = 1'b0;
    forever begin
      @(negedge clk);
      if (try_ack) begin
        try_ack = 1'b0;
        wcnt = 0;
      end else if (try_req) begin
        wcnt++;
        if (wcnt == 2 && !silent_mask[try_src]) begin
          try_ack  = 1'b1;
          try_pass = pass_mask[try_src];
        end
      end else begin
        wcnt = 0;
      end
    end
  end

  // monitor: pops the expected code on every new request (R1 R2 R4)
  initial begin
    logic prev;
    logic [2:0] e;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (in_reset) begin
        prev = 1'b0;
      end else begin
        if (try_req && !prev) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected attempt", try_src, 0);
          end else begin
            e = exp_q.pop_front();
            chk(try_src == e, "R1/R2/R3 attempt order", try_src, e);
          end
          chk(try_addr == 32'd512, "R4 image address", try_addr, 512);
        end
        prev = try_req;
      end
    end
  end

  task automatic push(input logic [2:0] s);
    exp_q.push_back(s);
  endtask

  task automatic run_case(input string tag, input logic [2:0] st, input bit frc,
                          input bit to_sd, input bit cold, input logic [7:0] pm,
                          input logic [7:0] sm, input bit exp_done,
                          input logic [2:0] exp_src);
    strap = st; rcv_force = frc; rcv_to_sd = to_sd;
    pass_mask = pm; silent_mask = sm;
    in_reset = 1'b1;
    rst_n = 1'b0;
    if (cold) por_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!try_req && !boot_done && !boot_fail && boot_src == 3'd0,
        "R10 reset outputs", {try_req, boot_done, boot_fail}, 0);
    rst_n = 1'b1; por_n = 1'b1;
    in_reset = 1'b0;
    repeat (10) @(negedge clk);
    rcv_force = 1'b0;
    for (int i = 0; i < 3000 && !boot_done && !boot_fail; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, {tag, " R2 all attempts made"}, exp_q.size(), 0);
    exp_q.delete();
    if (exp_done) begin
      chk(boot_done && !boot_fail, {tag, " R9 done flag"}, boot_done, 1);
      chk(boot_src == exp_src, {tag, " R9 passing source"}, boot_src, exp_src);
    end else begin
      chk(boot_fail && !boot_done, {tag, " R8 fail flag"}, boot_fail, 1);
      chk(boot_src == 3'd0, {tag, " R8 source cleared"}, boot_src, 0);
    end
    chk(!try_req, {tag, " R8/R9 no request after end"}, try_req, 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    tmo_limit = 16'd20;
    por_n = 1'b0; rst_n = 1'b0; in_reset = 1'b1;
    strap = 3'b111; rcv_force = 1'b0; rcv_to_sd = 1'b0;
    pass_mask = '0; silent_mask = '0;

    // R1 R3: production strap, SD passes
    push(3); push(4); push(5); push(6);
    run_case("s111", 3'b111, 0, 0, 1, 8'h40, 8'h00, 1, 3'd6);
    // R8: strap 000, nothing passes
    push(7); push(1); push(3); push(4); push(5); push(6);
    run_case("s000", 3'b000, 0, 0, 1, 8'h00, 8'h00, 0, 3'd0);
    // R1 R9: strap 001, eMMC main passes
    push(7); push(3);
    run_case("s001", 3'b001, 0, 0, 1, 8'h08, 8'h00, 1, 3'd3);
    // R1: strap 010, USB last and passes
    push(1); push(3); push(4); push(5); push(6); push(7);
    run_case("s010", 3'b010, 0, 0, 1, 8'h80, 8'h00, 1, 3'd7);
    // R5: strap 011, SPI NAND silent (timeout), all fail
    push(2); push(3); push(4); push(5); push(7);
    run_case("s011_tmo", 3'b011, 0, 0, 1, 8'h00, 8'h04, 0, 3'd0);
    // R11: alias straps
    push(7); push(1); push(3); push(4); push(5); push(6);
    run_case("s100", 3'b100, 0, 0, 1, 8'h40, 8'h00, 1, 3'd6);
    push(7); push(3); push(4); push(5);
    run_case("s101", 3'b101, 0, 0, 1, 8'h20, 8'h00, 1, 3'd5);
    push(1);
    run_case("s110", 3'b110, 0, 0, 1, 8'h02, 8'h00, 1, 3'd1);
    // R6: SD override ahead of list
    push(6); push(3); push(4);
    run_case("ovr_sd", 3'b111, 1, 1, 1, 8'h10, 8'h00, 1, 3'd4);
    // R6 R7: USB override, then warm reset keeps it, cold reset clears it
    push(7); push(3); push(4); push(5);
    run_case("ovr_usb", 3'b111, 1, 0, 1, 8'h20, 8'h00, 1, 3'd5);
    push(7); push(3); push(4); push(5);
    run_case("R7_warm", 3'b111, 0, 0, 0, 8'h20, 8'h00, 1, 3'd5);
    push(3); push(4); push(5);
    run_case("R7_cold", 3'b111, 0, 0, 1, 8'h20, 8'h00, 1, 3'd5);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule